// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a logical address into a physical address by reading a two-level page table held in memory. The logical address has three fields: an outer index, an inner index and a page offset. The walker adds the outer index, scaled by the entry size, to a table base taken from a base register, and reads that outer entry. A valid outer entry names the page that holds the matching slice of the inner table. The walker then indexes that page with the inner index and reads the inner entry. A valid inner entry supplies the frame number. The result is the frame number followed by the untouched offset.

The CPU side uses a ready/valid request and a one-cycle response pulse, which carries either a physical address or a fault. The fault names the level whose entry was invalid. The memory side is a read port that allows one request in flight: `mem_req_o` is a one-cycle launch, and `mem_rvalid_i` returns the entry. The outer base is sampled together with the logical address when a request is accepted. Intermediate entries are not cached, so every translation makes its reads again.

Top module: `ptw2_walker`

## Requirements
- R1: While `rst_ni` is low and after its release, `req_ready_o` is 1, `resp_valid_o` is 0 and `mem_req_o` is 0.
- R2: The logical address is split as outer index = `req_vaddr_i[VA_W-1:VA_W-OUTER_W]`, inner index = the next INNER_W bits and offset = `req_vaddr_i[OFF_W-1:0]`. The first read goes to `outer_base_i + outer_index*ENTRY_BYTES`, modulo 2^PA_W.
- R3: A table entry is FRAME_W+1 bits wide. Bit FRAME_W is the valid flag and bits FRAME_W-1:0 are the frame number. After a valid outer entry, the second read goes to `frame*2^OFF_W + inner_index*ENTRY_BYTES`.
- R4: When both entries are valid, the response has `resp_fault_o`=0 and `resp_paddr_o` = inner frame * 2^OFF_W + offset.
- R5: An invalid outer entry ends the walk after a single read. The response has `resp_fault_o`=1, `resp_fault_lvl_o`=0 and `resp_paddr_o`=0.
- R6: An invalid inner entry ends the walk after two reads. The response has `resp_fault_o`=1, `resp_fault_lvl_o`=1 and `resp_paddr_o`=0.
- R7: `mem_req_o` is high for exactly one cycle per read. No new read is launched until `mem_rvalid_i` has returned the previous one.
- R8: A request is accepted only when `req_ready_o` is 1, and the accepting edge launches the outer read. Until the response, `req_ready_o` stays 0. Changes on `req_valid_i`, `req_vaddr_i` and `outer_base_i` during that time have no effect on the result.
- R9: `resp_valid_o` is high for exactly one cycle, and `req_ready_o` is 1 again in the following cycle. Let D1 and D2 be the number of edges from the edge that launches a read to the edge that samples its `mem_rvalid_i`, for the outer and inner read. If the request is accepted on edge k, the response is visible in the cycle after edge k+D1 for an outer fault, and in the cycle after edge k+D1+D2 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request can be taken |
| req_vaddr_i | input | VA_W | Logical address to translate |
| outer_base_i | input | PA_W | Base address of the outer table |
| resp_valid_o | output | 1 | Response pulse |
| resp_fault_o | output | 1 | Walk hit an invalid entry |
| resp_fault_lvl_o | output | 1 | Faulting level: 0 outer, 1 inner |
| resp_paddr_o | output | PA_W | Physical address, zero on fault |
| mem_req_o | output | 1 | Read launch, one cycle |
| mem_addr_o | output | PA_W | Read address of the entry |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | FRAME_W+1 | Entry returned by memory |

## Verification
The bench memory model draws each read latency per walk, so D1 and D2 are known before the request is driven. Inputs change at falling edges. The bench counts falling edges from the one on which the request is driven and expects the response pulse on edge 1+D1 for an outer fault and on edge 1+D1+D2 otherwise. It compares the falling edge on which the response actually appears with that figure, and on the next falling edge it checks that the pulse has dropped and the walker is ready again. The model also records the address of every launched read and flags any launch made while a read is still outstanding. The bench then compares the recorded addresses and the number of reads against its own walk of the same table.

// File: rtl/ptw2_pkg.sv
package ptw2_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OUTER,
    ST_RD_INNER,
    ST_DONE,
    ST_FAULT
  } walk_st_e;

  typedef enum logic {
    LVL_OUTER = 1'b0,
    LVL_INNER = 1'b1
  } fault_lvl_e;

endpackage

// File: rtl/ptw2_vsplit.sv
module ptw2_vsplit #(
  parameter int OUTER_W = 8,
  parameter int INNER_W = 6,
  parameter int OFF_W   = 10,
  localparam int VA_W   = OUTER_W + INNER_W + OFF_W
) (
  input  logic [VA_W-1:0]    vaddr_i,
  output logic [OUTER_W-1:0] p1_o,
  output logic [INNER_W-1:0] p2_o,
  output logic [OFF_W-1:0]   off_o
);

  assign p1_o  = vaddr_i[VA_W-1 -: OUTER_W];
  assign p2_o  = vaddr_i[OFF_W +: INNER_W];
  assign off_o = vaddr_i[OFF_W-1:0];

endmodule

// File: rtl/ptw2_eaddr.sv
module ptw2_eaddr #(
  parameter int PA_W        = 26,
  parameter int IDX_W       = 8,
  parameter int ENTRY_BYTES = 4
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [PA_W-1:0]  addr_o
);

  localparam int  ENTRY_SHIFT = $clog2(ENTRY_BYTES);
  localparam bit  POW2        = ((1 << ENTRY_SHIFT) == ENTRY_BYTES);

  logic [PA_W-1:0] idx_ext;
  logic [PA_W-1:0] scaled;

  assign idx_ext = {{(PA_W-IDX_W){1'b0}}, idx_i};

  generate
    if (POW2) begin : g_shift
      assign scaled = idx_ext << ENTRY_SHIFT;
    end else begin : g_mult
      localparam logic [PA_W-1:0] EB = PA_W'(ENTRY_BYTES);
      assign scaled = idx_ext * EB;
    end
  endgenerate

  // wraps modulo 2^PA_W
  assign addr_o = base_i + scaled;

endmodule

// File: rtl/ptw2_pte_dec.sv
module ptw2_pte_dec #(
  parameter int FRAME_W  = 16,
  localparam int ENTRY_W = FRAME_W + 1
) (
  input  logic [ENTRY_W-1:0] entry_i,
  output logic               valid_o,
  output logic [FRAME_W-1:0] frame_o
);

  assign valid_o = entry_i[FRAME_W];
  assign frame_o = entry_i[FRAME_W-1:0];

endmodule

// File: rtl/ptw2_fsm.sv
module ptw2_fsm
  import ptw2_pkg::*;
#(
  parameter int INNER_W = 6,
  parameter int OFF_W   = 10,
  parameter int FRAME_W = 16,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [PA_W-1:0]    outer_ea_i,
  input  logic [INNER_W-1:0] p2_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [PA_W-1:0]    inner_ea_i,
  input  logic               pte_valid_i,
  input  logic [FRAME_W-1:0] pte_frame_i,
  input  logic               mem_rvalid_i,
  output logic [INNER_W-1:0] p2_o,
  output logic               req_ready_o,
  output logic               resp_valid_o,
  output logic               resp_fault_o,
  output logic               resp_fault_lvl_o,
  output logic [PA_W-1:0]    resp_paddr_o,
  output logic               mem_req_o,
  output logic [PA_W-1:0]    mem_addr_o
);

  walk_st_e           state_q;
  fault_lvl_e         lvl_q;
  logic               mem_req_q;
  logic [PA_W-1:0]    mem_addr_q;
  logic [INNER_W-1:0] p2_q;
  logic [OFF_W-1:0]   off_q;
  logic [PA_W-1:0]    paddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      lvl_q      <= LVL_OUTER;
      mem_req_q  <= 1'b0;
      mem_addr_q <= '0;
      p2_q       <= '0;
      off_q      <= '0;
      paddr_q    <= '0;
    end else begin
      mem_req_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            state_q    <= ST_RD_OUTER;
            mem_req_q  <= 1'b1;
            mem_addr_q <= outer_ea_i;
            p2_q       <= p2_i;
            off_q      <= off_i;
            paddr_q    <= '0;
            lvl_q      <= LVL_OUTER;
          end
        end
        ST_RD_OUTER: begin
          if (mem_rvalid_i) begin
            if (pte_valid_i) begin
              state_q    <= ST_RD_INNER;
              mem_req_q  <= 1'b1;
              mem_addr_q <= inner_ea_i;
            end else begin
              state_q <= ST_FAULT;
              lvl_q   <= LVL_OUTER;
            end
          end
        end
        ST_RD_INNER: begin
          if (mem_rvalid_i) begin
            if (pte_valid_i) begin
              state_q <= ST_DONE;
              paddr_q <= {pte_frame_i, off_q};
            end else begin
              state_q <= ST_FAULT;
              lvl_q   <= LVL_INNER;
            end
          end
        end
        ST_DONE, ST_FAULT: state_q <= ST_IDLE;
        default:           state_q <= ST_IDLE;
      endcase
    end
  end

  assign p2_o             = p2_q;
  assign req_ready_o      = (state_q == ST_IDLE);
  assign resp_valid_o     = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign resp_fault_o     = (state_q == ST_FAULT);
  assign resp_fault_lvl_o = lvl_q;
  assign resp_paddr_o     = paddr_q;
  assign mem_req_o        = mem_req_q;
  assign mem_addr_o       = mem_addr_q;

  // R8
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (mem_req_o && !req_ready_o));

  // R9
  resp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> (!resp_valid_o && req_ready_o));

  // R4
  offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_fault_o) |-> (resp_paddr_o[OFF_W-1:0] == off_q));

  // R5, R6
  fault_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_fault_o) |-> (resp_paddr_o == '0));

endmodule

// File: rtl/ptw2_walker.sv
module ptw2_walker #(
  parameter int OUTER_W     = 8,
  parameter int INNER_W     = 6,
  parameter int OFF_W       = 10,
  parameter int FRAME_W     = 16,
  parameter int ENTRY_BYTES = 4,
  localparam int VA_W       = OUTER_W + INNER_W + OFF_W,
  localparam int PA_W       = FRAME_W + OFF_W,
  localparam int ENTRY_W    = FRAME_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VA_W-1:0]    req_vaddr_i,
  input  logic [PA_W-1:0]    outer_base_i,
  output logic               resp_valid_o,
  output logic               resp_fault_o,
  output logic               resp_fault_lvl_o,
  output logic [PA_W-1:0]    resp_paddr_o,
  output logic               mem_req_o,
  output logic [PA_W-1:0]    mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [ENTRY_W-1:0] mem_rdata_i
);

  logic [OUTER_W-1:0] p1;
  logic [INNER_W-1:0] p2_in;
  logic [INNER_W-1:0] p2_held;
  logic [OFF_W-1:0]   off_in;
  logic [PA_W-1:0]    outer_ea;
  logic [PA_W-1:0]    inner_ea;
  logic [PA_W-1:0]    inner_base;
  logic               pte_valid;
  logic [FRAME_W-1:0] pte_frame;

  ptw2_vsplit #(
    .OUTER_W(OUTER_W), .INNER_W(INNER_W), .OFF_W(OFF_W)
  ) u_split (
    .vaddr_i(req_vaddr_i), .p1_o(p1), .p2_o(p2_in), .off_o(off_in)
  );

  ptw2_eaddr #(
    .PA_W(PA_W), .IDX_W(OUTER_W), .ENTRY_BYTES(ENTRY_BYTES)
  ) u_outer_ea (
    .base_i(outer_base_i), .idx_i(p1), .addr_o(outer_ea)
  );

  ptw2_pte_dec #(
    .FRAME_W(FRAME_W)
  ) u_pte (
    .entry_i(mem_rdata_i), .valid_o(pte_valid), .frame_o(pte_frame)
  );

  // inner table page is frame-aligned
  assign inner_base = {pte_frame, {OFF_W{1'b0}}};

  ptw2_eaddr #(
    .PA_W(PA_W), .IDX_W(INNER_W), .ENTRY_BYTES(ENTRY_BYTES)
  ) u_inner_ea (
    .base_i(inner_base), .idx_i(p2_held), .addr_o(inner_ea)
  );

  ptw2_fsm #(
    .INNER_W(INNER_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)
  ) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .outer_ea_i      (outer_ea),
    .p2_i            (p2_in),
    .off_i           (off_in),
    .inner_ea_i      (inner_ea),
    .pte_valid_i     (pte_valid),
    .pte_frame_i     (pte_frame),
    .mem_rvalid_i    (mem_rvalid_i),
    .p2_o            (p2_held),
    .req_ready_o     (req_ready_o),
    .resp_valid_o    (resp_valid_o),
    .resp_fault_o    (resp_fault_o),
    .resp_fault_lvl_o(resp_fault_lvl_o),
    .resp_paddr_o    (resp_paddr_o),
    .mem_req_o       (mem_req_o),
    .mem_addr_o      (mem_addr_o)
  );

  // checker state: one read in flight
  logic rd_open_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rd_open_q <= 1'b0;
    else if (mem_req_o)     rd_open_q <= 1'b1;
    else if (mem_rvalid_i)  rd_open_q <= 1'b0;
  end

  // R7
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !rd_open_q);

  // R7
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (req_ready_o && !resp_valid_o && !mem_req_o));

endmodule

// File: tb/test_ptw2_walker.sv
`timescale 1ns/1ps
module test_ptw2_walker;

  localparam int OUTER_W = 8;
  localparam int INNER_W = 6;
  localparam int OFF_W   = 10;
  localparam int FRAME_W = 16;
  localparam int EB      = 4;
  localparam int VA_W    = OUTER_W + INNER_W + OFF_W;
  localparam int PA_W    = FRAME_W + OFF_W;
  localparam int ENTRY_W = FRAME_W + 1;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               req_valid = 1'b0;
  logic               req_ready;
  logic [VA_W-1:0]    vaddr = '0;
  logic [PA_W-1:0]    base = '0;
  logic               resp_valid;
  logic               resp_fault;
  logic               resp_lvl;
  logic [PA_W-1:0]    resp_paddr;
  logic               mem_req;
  logic [PA_W-1:0]    mem_addr;
  logic               mem_rvalid = 1'b0;
  logic [ENTRY_W-1:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  ptw2_walker i_ptw2_walker (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(vaddr), .outer_base_i(base),
    .resp_valid_o(resp_valid), .resp_fault_o(resp_fault),
    .resp_fault_lvl_o(resp_lvl), .resp_paddr_o(resp_paddr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  int nchk = 0;
  int nfail = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [ENTRY_W-1:0] ovr [int unsigned];
  logic [31:0]        hseed = 32'h5A17C3E9;
  int                 lat1 = 1, lat2 = 1;
  int                 nreq = 0;
  int                 cnt = 0;
  bit                 pend = 1'b0;
  logic [PA_W-1:0]    alog1 = '0, alog2 = '0, raddr = '0;

  function automatic logic [ENTRY_W-1:0] mem_word(input logic [PA_W-1:0] a);
    logic [31:0] h;
    if (ovr.exists(32'(a))) return ovr[32'(a)];
    h = (32'(a) * 32'h9E3779B1) ^ hseed;
    return {(h[31:30] != 2'b00), h[20:5]};
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid = 1'b0;
      cnt = 0;
      pend = 1'b0;
    end else begin
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem_word(raddr);
          pend = 1'b0;
        end else mem_rvalid = 1'b0;
      end else mem_rvalid = 1'b0;
      if (mem_req) begin
        // R7: no launch while a read is open
        chk(!pend, "R7 launch while read open", 64'(pend), 64'd0);
        nreq++;
        if (nreq == 1) alog1 = mem_addr; else alog2 = mem_addr;
        raddr = mem_addr;
        cnt = (nreq == 1) ? lat1 : lat2;
        pend = 1'b1;
      end
    end
  end

  // ---------------- reference walk ----------------
  task automatic walk(input logic [VA_W-1:0] va, input logic [PA_W-1:0] b, input int l1, input int l2);
    logic [OUTER_W-1:0] p1;
    logic [INNER_W-1:0] p2;
    logic [OFF_W-1:0]   off;
    logic [PA_W-1:0]    oa, ia, exp_pa;
    logic [ENTRY_W-1:0] oe, ie;
    bit                 exp_f, exp_l;
    int                 exp_n, exp_t, n;

    p1  = va[VA_W-1 -: OUTER_W];
    p2  = va[OFF_W +: INNER_W];
    off = va[OFF_W-1:0];
    oa  = b + PA_W'(p1) * PA_W'(EB);
    oe  = mem_word(oa);
    ia  = {oe[FRAME_W-1:0], {OFF_W{1'b0}}} + PA_W'(p2) * PA_W'(EB);
    ie  = mem_word(ia);
    if (!oe[FRAME_W]) begin
      exp_f = 1; exp_l = 0; exp_pa = '0; exp_n = 1; exp_t = 2 + l1;
    end else if (!ie[FRAME_W]) begin
      exp_f = 1; exp_l = 1; exp_pa = '0; exp_n = 2; exp_t = 3 + l1 + l2;
    end else begin
      exp_f = 0; exp_l = 0; exp_pa = {ie[FRAME_W-1:0], off}; exp_n = 2; exp_t = 3 + l1 + l2;
    end

    lat1 = l1; lat2 = l2; nreq = 0;
    chk(req_ready == 1'b1, "R8 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; vaddr = va; base = b;
    @(negedge clk);
    // R8: busy, garbage on inputs must be ignored
    chk(req_ready == 1'b0, "R8 ready low while walking", 64'(req_ready), 64'd0);
    vaddr = VA_W'($urandom); base = PA_W'($urandom);
    @(negedge clk);
    req_valid = 1'b0;
    n = 2;
    while (!resp_valid && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk(n == exp_t, "R9 response timing", 64'(n), 64'(exp_t));
    chk(alog1 == oa, "R2 outer entry address", 64'(alog1), 64'(oa));
    chk(nreq == exp_n, exp_f && !exp_l ? "R5 read count" : "R6 read count", 64'(nreq), 64'(exp_n));
    if (exp_n == 2) chk(alog2 == ia, "R3 inner entry address", 64'(alog2), 64'(ia));
    chk(resp_fault == exp_f, "R4 fault flag", 64'(resp_fault), 64'(exp_f));
    if (exp_f) begin
      chk(resp_lvl == exp_l, exp_l ? "R6 fault level" : "R5 fault level", 64'(resp_lvl), 64'(exp_l));
      chk(resp_paddr == '0, exp_l ? "R6 paddr zero" : "R5 paddr zero", 64'(resp_paddr), 64'd0);
    end else begin
      chk(resp_paddr == exp_pa, "R4 physical address", 64'(resp_paddr), 64'(exp_pa));
    end
    @(negedge clk);
    chk(!resp_valid && req_ready, "R9 pulse end and ready", {62'd0, resp_valid, req_ready}, 64'd1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd2718));
    #1;
    // R1 during reset
    chk(req_ready && !resp_valid && !mem_req, "R1 reset state",
        {61'd0, req_ready, resp_valid, mem_req}, 64'h4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req, "R1 after release",
        {61'd0, req_ready, resp_valid, mem_req}, 64'h4);

    // R4: (1, 2, 121) with inner frame 708 and 1K pages
    ovr[32'h20004] = {1'b1, 16'd5};
    ovr[32'd5*1024 + 8] = {1'b1, 16'd708};
    walk({8'd1, 6'd2, 10'd121}, 26'h20000, 1, 1);
    chk(resp_paddr == 26'd725113, "R4 worked example", 64'(resp_paddr), 64'd725113);

    // R5: outer entry invalid, frame bits set but ignored
    ovr[32'h3000C] = {1'b0, 16'hFFFF};
    walk({8'd3, 6'd9, 10'd7}, 26'h30000, 4, 1);

    // R6: inner entry invalid at the last inner index
    ovr[32'h30010] = {1'b1, 16'd9};
    ovr[32'd9*1024 + 252] = {1'b0, 16'd77};
    walk({8'd4, 6'd63, 10'd0}, 26'h30000, 2, 3);

    // R2, R3: all-ones indices and offset, outer address wraps
    ovr[32'h3F8] = {1'b1, 16'hFFFF};
    ovr[32'h3FFFCFC] = {1'b1, 16'hABCD};
    walk({8'd255, 6'd63, 10'd1023}, 26'h3FFFFFC, 3, 1);

    // random walks
    for (int i = 0; i < 300; i++) begin
      walk(VA_W'($urandom), PA_W'($urandom), 1 + int'($urandom % 4), 1 + int'($urandom % 4));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule